// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Context Shadow

This block keeps the return addresses of a small 4-bit controller core in a circular stack of eight entries. Three kinds of event each take one entry: a subroutine call, entry into an interrupt handler and a table-reference fetch. A return, or the end of a table reference, gives one entry back. The popped return address is always visible on an output. The current pointer is also brought out so the core can move it into its accumulator.

The stack does not detect overflow. After reset the pointer sits at 7. A push first advances the pointer and then writes, so the first push lands in entry 0. A ninth nested push wraps the pointer round and overwrites entry 0 without any warning. A separate pointer-reset input, used on leaving the low-power back-up mode, returns the pointer to 7.

Next to the stack sits a single-stage context shadow. On interrupt entry it captures the data pointer, the carry and skip flags, and the A and B registers. The core reads them back when the handler returns, so a pending skip survives the interrupt. Calls and table references never write the shadow.

Top module: `retstk_top`

## Requirements
- R1: Reset sets the pointer `sp_val` to 7 and clears every stack entry and every shadow field.
- R2: A push (exactly one of `call_req`, `irq_req` or `tref_req` high, with `pop_req` low) advances `sp_val` by one modulo 8 at the clock edge and stores `push_pc` in the entry at the new pointer. From that edge on, `top_pc` shows `push_pc`.
- R3: A push made while `sp_val` is 7 wraps the pointer to 0 and overwrites entry 0. No output signals the overflow.
- R4: `top_pc` always shows the entry at the current pointer. A pop (`pop_req` high with no push) decrements `sp_val` modulo 8, so a pop at 0 gives 7, and it leaves every entry unchanged.
- R5: A push and a pop in the same cycle leave `sp_val` unchanged and replace the entry at the current pointer with `push_pc`.
- R6: `bkup_exit` high at a clock edge forces `sp_val` to 7. It overrides any push or pop in that cycle, and no entry is written.
- R7: `irq_req` high at a clock edge captures `dp_in`, `cy_in`, `sk_in`, `a_in` and `b_in` into the shadow. The captured values appear on `sv_dp`, `sv_cy`, `sv_sk`, `sv_a` and `sv_b` after that edge.
- R8: The shadow outputs do not change in any cycle without `irq_req`. This holds for calls, table references, pops and `bkup_exit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bkup_exit | input | 1 | Pointer reset on leaving back-up mode |
| call_req | input | 1 | Push request from a subroutine call |
| irq_req | input | 1 | Push request from interrupt entry; also captures the context |
| tref_req | input | 1 | Push request from a table-reference fetch |
| pop_req | input | 1 | Release request from a return or the end of a table reference |
| push_pc | input | PCW (14) | Address to be stored by a push |
| top_pc | output | PCW (14) | Entry at the current pointer |
| sp_val | output | 3 | Current stack pointer |
| dp_in | input | DPW (10) | Data pointer to be saved |
| cy_in | input | 1 | Carry flag to be saved |
| sk_in | input | 1 | Skip flag to be saved |
| a_in | input | 4 | Register A to be saved |
| b_in | input | 4 | Register B to be saved |
| sv_dp | output | DPW (10) | Saved data pointer |
| sv_cy | output | 1 | Saved carry flag |
| sv_sk | output | 1 | Saved skip flag |
| sv_a | output | 4 | Saved register A |
| sv_b | output | 4 | Saved register B |

## Verification
The pointer, the stored entries and the shadow all change at the clock edge on which a request is sampled. `sp_val` and the shadow outputs are therefore due one edge after the request. `top_pc` is a combinational read at the new pointer, so it is valid in the same cycle after that edge. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares all outputs at the next falling edge, before driving the next request, so each result is checked exactly one edge after its cause. For a pop, the value compared is the entry left on top afterwards, which the model takes from its own entry array.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_SWAP = 2'd3
   } stk_op_e;

   function automatic stk_op_e stk_decode(input logic push, input logic pop);
      case ({push, pop})
         2'b10:   return STK_PUSH;
         2'b01:   return STK_POP;
         2'b11:   return STK_SWAP;
         default: return STK_HOLD;
      endcase
   endfunction

endpackage

// File: rtl/retstk_ptr.sv
module retstk_ptr
   import retstk_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTRW = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bkup_exit,
   input  stk_op_e         op,
   output logic [PTRW-1:0] sp,
   output logic [PTRW-1:0] wr_idx
);

   localparam logic [PTRW-1:0] SP_INIT = PTRW'(DEPTH - 1);
   localparam logic [PTRW-1:0] STEP    = PTRW'(1);

   logic [PTRW-1:0] sp_inc;
   logic [PTRW-1:0] sp_dec;

   assign sp_inc = sp + STEP;
   assign sp_dec = sp - STEP;
   assign wr_idx = (op == STK_SWAP) ? sp : sp_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= SP_INIT;
      end else if (bkup_exit) begin
         sp <= SP_INIT;
      end else begin
         case (op)
            STK_PUSH: sp <= sp_inc;
            STK_POP:  sp <= sp_dec;
            default:  sp <= sp;
         endcase
      end
   end

   // R2
   sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == STK_PUSH && !bkup_exit) |=> sp == PTRW'($past(sp) + STEP));

   // R4
   sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == STK_POP && !bkup_exit) |=> sp == PTRW'($past(sp) - STEP));

   // R5
   sp_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == STK_SWAP && !bkup_exit) |=> $stable(sp));

   // R6
   sp_bkup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bkup_exit |=> sp == SP_INIT);

endmodule

// File: rtl/retstk_ram.sv
module retstk_ram #(
   parameter int DEPTH          = 8,
   parameter int PCW            = 14,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTRW = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PTRW-1:0] wr_idx,
   input  logic [PCW-1:0]  wr_data,
   input  logic [PTRW-1:0] rd_idx,
   output logic [PCW-1:0]  rd_data
);

   logic [PCW-1:0] ent [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic hit;
      assign hit = we && (wr_idx == PTRW'(gi));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent[gi] <= '0;
            else if (hit) ent[gi] <= wr_data;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) ent[gi] <= wr_data;
         end
      end
   end

   assign rd_data = ent[rd_idx];

endmodule

// File: rtl/retstk_shadow.sv
module retstk_shadow #(
   parameter int DPW = 10,
   parameter int RW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cap,
   input  logic [DPW-1:0] dp_in,
   input  logic           cy_in,
   input  logic           sk_in,
   input  logic [RW-1:0]  a_in,
   input  logic [RW-1:0]  b_in,
   output logic [DPW-1:0] dp_q,
   output logic           cy_q,
   output logic           sk_q,
   output logic [RW-1:0]  a_q,
   output logic [RW-1:0]  b_q
);

   typedef struct packed {
      logic [DPW-1:0] dp;
      logic           cy;
      logic           sk;
      logic [RW-1:0]  a;
      logic [RW-1:0]  b;
   } ctx_t;

   ctx_t held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (cap) held <= '{dp: dp_in, cy: cy_in, sk: sk_in, a: a_in, b: b_in};
   end

   assign dp_q = held.dp;
   assign cy_q = held.cy;
   assign sk_q = held.sk;
   assign a_q  = held.a;
   assign b_q  = held.b;

   // R7
   shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> {dp_q, cy_q, sk_q, a_q, b_q} ==
              $past({dp_in, cy_in, sk_in, a_in, b_in}));

   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable({dp_q, cy_q, sk_q, a_q, b_q}));

endmodule

// File: rtl/retstk_top.sv
module retstk_top
   import retstk_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter int PCW            = 14,
   parameter int DPW            = 10,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTRW = $clog2(DEPTH),
   localparam int RW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bkup_exit,
   input  logic            call_req,
   input  logic            irq_req,
   input  logic            tref_req,
   input  logic            pop_req,
   input  logic [PCW-1:0]  push_pc,
   output logic [PCW-1:0]  top_pc,
   output logic [PTRW-1:0] sp_val,
   input  logic [DPW-1:0]  dp_in,
   input  logic            cy_in,
   input  logic            sk_in,
   input  logic [RW-1:0]   a_in,
   input  logic [RW-1:0]   b_in,
   output logic [DPW-1:0]  sv_dp,
   output logic            sv_cy,
   output logic            sv_sk,
   output logic [RW-1:0]   sv_a,
   output logic [RW-1:0]   sv_b
);

   initial begin : prm_chk
      depth_pow2_chk: assert ((DEPTH >= 2) && ((1 << PTRW) == DEPTH))
         else $error("retstk_top: DEPTH must be a power of two, at least 2");
      width_chk: assert ((PCW >= 1) && (DPW >= 1))
         else $error("retstk_top: PCW and DPW must be positive");
   end

   logic            any_push;
   stk_op_e         op;
   logic [PTRW-1:0] wr_idx;
   logic            we;

   assign any_push = call_req | irq_req | tref_req;
   assign op       = stk_decode(any_push, pop_req);
   assign we       = (op == STK_PUSH || op == STK_SWAP) && !bkup_exit;

   retstk_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bkup_exit (bkup_exit),
      .op        (op),
      .sp        (sp_val),
      .wr_idx    (wr_idx)
   );

   retstk_ram #(
      .DEPTH          (DEPTH),
      .PCW            (PCW),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .wr_idx  (wr_idx),
      .wr_data (push_pc),
      .rd_idx  (sp_val),
      .rd_data (top_pc)
   );

   retstk_shadow #(.DPW(DPW), .RW(RW)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (irq_req),
      .dp_in (dp_in),
      .cy_in (cy_in),
      .sk_in (sk_in),
      .a_in  (a_in),
      .b_in  (b_in),
      .dp_q  (sv_dp),
      .cy_q  (sv_cy),
      .sk_q  (sv_sk),
      .a_q   (sv_a),
      .b_q   (sv_b)
   );

   // R2 (one push source per cycle)
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({call_req, irq_req, tref_req}));

   // R2
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_push && !pop_req && !bkup_exit) |=> top_pc == $past(push_pc));

   // R5
   swap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_push && pop_req && !bkup_exit) |=> top_pc == $past(push_pc));

   // R6
   bkup_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bkup_exit |-> !we);

endmodule

// File: tb/retstk_top_tb.sv
module retstk_top_tb;

   localparam int PCW = 14;
   localparam int DPW = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bkup_exit = 1'b0;
   logic           call_req = 1'b0;
   logic           irq_req = 1'b0;
   logic           tref_req = 1'b0;
   logic           pop_req = 1'b0;
   logic [PCW-1:0] push_pc = '0;
   logic [PCW-1:0] top_pc;
   logic [2:0]     sp_val;
   logic [DPW-1:0] dp_in = '0;
   logic           cy_in = 1'b0;
   logic           sk_in = 1'b0;
   logic [3:0]     a_in = '0;
   logic [3:0]     b_in = '0;
   logic [DPW-1:0] sv_dp;
   logic           sv_cy;
   logic           sv_sk;
   logic [3:0]     sv_a;
   logic [3:0]     sv_b;

   always #4 clk = ~clk;

   retstk_top u_dut (
      .clk(clk), .rst_n(rst_n), .bkup_exit(bkup_exit),
      .call_req(call_req), .irq_req(irq_req), .tref_req(tref_req),
      .pop_req(pop_req), .push_pc(push_pc), .top_pc(top_pc), .sp_val(sp_val),
      .dp_in(dp_in), .cy_in(cy_in), .sk_in(sk_in), .a_in(a_in), .b_in(b_in),
      .sv_dp(sv_dp), .sv_cy(sv_cy), .sv_sk(sv_sk), .sv_a(sv_a), .sv_b(sv_b)
   );

   int total = 0;
   int bad   = 0;

   logic [PCW-1:0] m_ent [8];
   logic [2:0]     m_sp;
   logic [DPW+9:0] m_sh;

   function automatic logic [2:0] wrap_add(input logic [2:0] v, input int d);
      return 3'((int'(v) + d + 8) % 8);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " sp"},     32'(sp_val), 32'(m_sp));
      chk({tag, " top"},    32'(top_pc), 32'(m_ent[m_sp]));
      chk({tag, " shadow"}, 32'({sv_dp, sv_cy, sv_sk, sv_a, sv_b}), 32'(m_sh));
   endtask

   // one cycle: drive at falling edge, model at rising edge, check at next falling edge
   task automatic step(input logic c, input logic i, input logic t, input logic p,
                       input logic bk, input logic [PCW-1:0] pc, input string tag);
      logic push;
      call_req = c; irq_req = i; tref_req = t; pop_req = p; bkup_exit = bk;
      push_pc = pc;
      dp_in = DPW'($urandom); cy_in = 1'($urandom); sk_in = 1'($urandom);
      a_in = 4'($urandom); b_in = 4'($urandom);
      @(posedge clk);
      push = c | i | t;
      if (i) m_sh = {dp_in, cy_in, sk_in, a_in, b_in};
      if (bk)             m_sp = 3'd7;
      else if (push && p) m_ent[m_sp] = pc;
      else if (push) begin
         m_sp = wrap_add(m_sp, 1);
         m_ent[m_sp] = pc;
      end else if (p)     m_sp = wrap_add(m_sp, -1);
      @(negedge clk);
      call_req = 1'b0; irq_req = 1'b0; tref_req = 1'b0; pop_req = 1'b0; bkup_exit = 1'b0;
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [DPW+9:0] sh_before;
      void'($urandom(32'd4242));
      for (int k = 0; k < 8; k++) m_ent[k] = '0;
      m_sp = 3'd7;
      m_sh = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1 reset");

      // R2 first push lands in entry 0
      step(1, 0, 0, 0, 0, 14'h0101, "R2 first push");
      chk("R2 first push at entry 0", 32'(sp_val), 32'd0);
      // R2 seven more pushes, then R3 a ninth wraps and overwrites entry 0
      for (int k = 1; k < 8; k++) step(0, 0, 1, 0, 0, PCW'(14'h0100 + k), "R2 fill");
      chk("R2 full at 7", 32'(sp_val), 32'd7);
      step(1, 0, 0, 0, 0, 14'h3ABC, "R3 wrap push");
      chk("R3 wrapped to 0", 32'(sp_val), 32'd0);
      chk("R3 entry 0 overwritten", 32'(top_pc), 32'h3ABC);

      // R4 pop at 0 wraps to 7, entry 7 unchanged
      step(0, 0, 0, 1, 0, 14'h1111, "R4 pop at 0");
      chk("R4 pop wraps to 7", 32'(sp_val), 32'd7);
      chk("R4 entry 7 kept", 32'(top_pc), 32'h0107);

      // R5 push and pop together
      step(1, 0, 0, 1, 0, 14'h2222, "R5 swap");
      chk("R5 sp unchanged", 32'(sp_val), 32'd7);
      chk("R5 top replaced", 32'(top_pc), 32'h2222);

      // R7 interrupt entry captures context; R8 call leaves shadow alone
      step(0, 1, 0, 0, 0, 14'h0333, "R7 irq");
      sh_before = m_sh;
      step(1, 0, 0, 0, 0, 14'h0444, "R8 call");
      chk("R8 shadow after call", 32'({sv_dp, sv_cy, sv_sk, sv_a, sv_b}), 32'(sh_before));
      step(0, 0, 1, 0, 0, 14'h0555, "R8 tref");
      step(0, 0, 0, 1, 0, 14'h0000, "R8 pop");
      chk("R8 shadow after tref and pop", 32'({sv_dp, sv_cy, sv_sk, sv_a, sv_b}), 32'(sh_before));

      // R6 bkup_exit overrides a push; entry at 2 kept
      step(0, 0, 1, 0, 1, 14'h3FFF, "R6 bkup with push");
      chk("R6 sp forced to 7", 32'(sp_val), 32'd7);
      step(1, 0, 0, 0, 0, 14'h0666, "R6 push after bkup");
      chk("R6 push lands at 0", 32'(sp_val), 32'd0);
      step(0, 0, 0, 1, 0, 14'h0000, "R6 pop to 7");
      chk("R6 entry 7 not written", 32'(top_pc), 32'(m_ent[7]));

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [PCW-1:0] pc;
         r  = int'($urandom % 32);
         pc = PCW'($urandom);
         if (r == 0)       step(0, 0, 0, 0, 1, pc, "R6 rnd bkup");
         else if (r < 7)   step(1, 0, 0, 0, 0, pc, "R2 rnd call");
         else if (r < 11)  step(0, 1, 0, 0, 0, pc, "R7 rnd irq");
         else if (r < 15)  step(0, 0, 1, 0, 0, pc, "R2 rnd tref");
         else if (r < 24)  step(0, 0, 0, 1, 0, pc, "R4 rnd pop");
         else if (r < 28)  step(r[0], 0, ~r[0], 1, 0, pc, "R5 rnd swap");
         else              step(0, 0, 0, 0, 0, pc, "R8 rnd idle");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule